// File: doc/BRIEF.md
# Keyed Configuration Port for a Multi-Function I/O Controller

This block is the configuration front end of a multi-function I/O controller, seen by a host over a byte-wide synchronous I/O bus. It has two ports next to each other. The lower one is the index port and the higher one is the data port. Configuration space is hidden until the host writes an unlock key to the index port. A different key hides it again. While configuration space is open, the host writes a register number to the index port and then reads or writes that register through the data port.

The registers let the host choose a logical device, read a fixed chip identifier, and read or write an activation bit and a 16-bit base address. The activation bit and base address are held separately for each logical device. The base address is stored in an unusual order: the low byte sits at the lower register number. The activation bit and base address of the embedded-controller logical device are also driven out as plain outputs, so that a downstream decoder can place that device's mailbox window.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the block is locked, the logical-device select is 0, and every enable bit and base-address byte is 0. In this state `ec_active` is 0, `ec_base` is 0x0000 and `io_rdata` is 0xFF.
- R2: Writing 0x55 to the index port (offset `BASE_OFS`) while locked unlocks the block. Writing 0xAA to the index port while unlocked locks it. Any other index-port write while unlocked, including 0x55, loads the index register.
- R3: While locked, data-port writes and non-key index-port writes change nothing, and reads of either port return 0xFF.
- R4: While unlocked, a read of the data port (offset `BASE_OFS`+1) returns the register selected by the index. A read of the index port returns the index itself. A read at any other offset returns 0xFF. Read data appears on `io_rdata` one clock after the read strobe and is held until the next read.
- R5: Index 0x07 is the logical-device select register. It is readable and writable as a full byte.
- R6: Index 0x20 returns the `CHIP_ID` parameter, which is 0xC6 or 0xC7. Writes to index 0x20 are ignored.
- R7: Index 0x30 holds the selected device's activation bit in bit 0. Only bit 0 is stored, and a read returns {7'b0, bit}.
- R8: Index 0x66 holds the low byte of the selected device's base address, and index 0x67 holds the high byte.
- R9: Enable and base-address registers exist once per logical device, for devices 0 to `NUM_LD`-1. A write changes only the currently selected device.
- R10: `ec_active` and `ec_base` always show the stored enable bit and base address of logical device `EC_LD` (0x0C by default).
- R11: Reads of an unimplemented index return 0x00. When the select register holds a value of `NUM_LD` or more, per-device reads return 0x00 and per-device writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_addr | input | 8 | Port offset of the access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| ec_active | output | 1 | Activation bit of the embedded-controller device |
| ec_base | output | 16 | Base address of the embedded-controller device |

## Verification
The assertions check on every cycle that the key writes move the lock state, that reads while locked return 0xFF, that the device outputs stay frozen while locked, and that the read data holds between read strobes. Only the bench scenarios can show the effects that depend on the register contents. These are the low/high byte order, the separate storage per logical device, the handling of an out-of-range select, and the fact that ignored writes leave nothing behind once the block is unlocked again.

// File: rtl/sio_cfg_port.sv
module sio_cfg_port #(
  parameter logic [7:0] CHIP_ID  = 8'hC7,
  parameter logic [7:0] BASE_OFS = 8'h00,
  parameter logic [7:0] EC_LD    = 8'h0C,
  parameter int         NUM_LD   = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        io_wr,
  input  logic        io_rd,
  input  logic [7:0]  io_addr,
  input  logic [7:0]  io_wdata,
  output logic [7:0]  io_rdata,
  output logic        ec_active,
  output logic [15:0] ec_base
);
  localparam int LDW = (NUM_LD > 1) ? $clog2(NUM_LD) : 1;
  localparam logic [7:0] KEY_ON  = 8'h55;
  localparam logic [7:0] KEY_OFF = 8'hAA;
  localparam logic [7:0] IX_SEL  = 8'h07;
  localparam logic [7:0] IX_ID   = 8'h20;
  localparam logic [7:0] IX_EN   = 8'h30;
  localparam logic [7:0] IX_LO   = 8'h66;
  localparam logic [7:0] IX_HI   = 8'h67;
  localparam logic [7:0] DAT_OFS = BASE_OFS + 8'd1;

  logic           locked;
  logic [7:0]     idx;
  logic [7:0]     ld_sel;
  logic           en [NUM_LD];
  logic [7:0]     lo [NUM_LD];
  logic [7:0]     hi [NUM_LD];
  logic [7:0]     rd_val;

  wire            hit_ix = (io_addr == BASE_OFS);
  wire            hit_dat = (io_addr == DAT_OFS);
  wire            sel_ok = (int'(ld_sel) < NUM_LD);
  wire [LDW-1:0]  slot = ld_sel[LDW-1:0];
  wire            cfg_wr = io_wr && hit_dat && !locked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      locked <= 1'b1;
      idx    <= 8'h00;
      ld_sel <= 8'h00;
    end else if (io_wr && hit_ix) begin
      if (locked) begin
        if (io_wdata == KEY_ON) locked <= 1'b0;
      end else if (io_wdata == KEY_OFF) begin
        locked <= 1'b1;
      end else begin
        idx <= io_wdata;
      end
    end else if (cfg_wr && idx == IX_SEL) begin
      ld_sel <= io_wdata;
    end
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_ld
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        en[g] <= 1'b0;
        lo[g] <= 8'h00;
        hi[g] <= 8'h00;
      end else if (cfg_wr && sel_ok && slot == LDW'(g)) begin
        case (idx)
          IX_EN:   en[g] <= io_wdata[0];
          IX_LO:   lo[g] <= io_wdata;
          IX_HI:   hi[g] <= io_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_val = 8'hFF;
    if (!locked) begin
      if (hit_ix) begin
        rd_val = idx;
      end else if (hit_dat) begin
        case (idx)
          IX_SEL:  rd_val = ld_sel;
          IX_ID:   rd_val = CHIP_ID;
          IX_EN:   rd_val = sel_ok ? {7'b0, en[slot]} : 8'h00;
          IX_LO:   rd_val = sel_ok ? lo[slot] : 8'h00;
          IX_HI:   rd_val = sel_ok ? hi[slot] : 8'h00;
          default: rd_val = 8'h00;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     io_rdata <= 8'hFF;
    else if (io_rd) io_rdata <= rd_val;
  end

  assign ec_active = en[EC_LD[LDW-1:0]];
  assign ec_base   = {hi[EC_LD[LDW-1:0]], lo[EC_LD[LDW-1:0]]};
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
  parameter logic [7:0] CHIP_ID  = 8'hC7,
  parameter logic [7:0] BASE_OFS = 8'h00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_addr,
  input logic [7:0]  io_wdata,
  input logic [7:0]  io_rdata,
  input logic        ec_active,
  input logic [15:0] ec_base,
  input logic        locked,
  input logic [7:0]  idx
);
  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    locked && io_wr && io_addr == BASE_OFS && io_wdata == 8'h55 |=> !locked);

  p_lock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && io_wr && io_addr == BASE_OFS && io_wdata == 8'hAA |=> locked);

  p_locked_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked && io_rd |=> io_rdata == 8'hFF);

  p_locked_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(ec_active) && $stable(ec_base));

  p_rdata_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  p_chip_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !locked && io_rd && io_addr == BASE_OFS + 8'd1 && idx == 8'h20 |=> io_rdata == CHIP_ID);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.CHIP_ID(CHIP_ID), .BASE_OFS(BASE_OFS)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .ec_active(ec_active),
  .ec_base(ec_base), .locked(locked), .idx(idx)
);

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  localparam logic [7:0] ID = 8'hC7;
  localparam int NLD = 16;
  localparam int ECL = 12;

  logic clk = 1'b0, rst_n = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_addr = 8'h00, io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic ec_active;
  logic [15:0] ec_base;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_port u_sio_cfg_port (.clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .ec_active(ec_active), .ec_base(ec_base));

  bit m_lock;
  logic [7:0] m_idx, m_sel;
  bit m_en [NLD];
  logic [7:0] m_lo [NLD], m_hi [NLD];

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_lock = 1; m_idx = 0; m_sel = 0;
    for (int i = 0; i < NLD; i++) begin m_en[i] = 0; m_lo[i] = 0; m_hi[i] = 0; end
  endtask

  function automatic logic [7:0] m_read(logic [7:0] a);
    bit ok = int'(m_sel) < NLD;
    if (m_lock) return 8'hFF;
    if (a == 8'h00) return m_idx;
    if (a != 8'h01) return 8'hFF;
    case (m_idx)
      8'h07: return m_sel;
      8'h20: return ID;
      8'h30: return ok ? {7'b0, m_en[m_sel[3:0]]} : 8'h00;
      8'h66: return ok ? m_lo[m_sel[3:0]] : 8'h00;
      8'h67: return ok ? m_hi[m_sel[3:0]] : 8'h00;
      default: return 8'h00;
    endcase
  endfunction

  task automatic m_write(logic [7:0] a, logic [7:0] d);
    bit ok = int'(m_sel) < NLD;
    if (a == 8'h00) begin
      if (m_lock) begin if (d == 8'h55) m_lock = 0; end
      else if (d == 8'hAA) m_lock = 1;
      else m_idx = d;
    end else if (a == 8'h01 && !m_lock) begin
      case (m_idx)
        8'h07: m_sel = d;
        8'h30: if (ok) m_en[m_sel[3:0]] = d[0];
        8'h66: if (ok) m_lo[m_sel[3:0]] = d;
        8'h67: if (ok) m_hi[m_sel[3:0]] = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
    m_write(a, d);
  endtask

  task automatic rd(string req, logic [7:0] a);
    logic [7:0] e;
    e = m_read(a);
    @(negedge clk); io_rd = 1; io_addr = a;
    @(negedge clk); io_rd = 0;
    chk(req, io_rdata, e);
  endtask

  task automatic rreg(string req, logic [7:0] ix);
    wr(8'h00, ix);
    rd(req, 8'h01);
  endtask

  task automatic chk_ec(string req);
    chk(req, {15'b0, ec_active}, {15'b0, m_en[ECL]});
    chk(req, ec_base, {m_hi[ECL], m_lo[ECL]});
  endtask

  initial begin
    logic [7:0] pick [8] = '{8'h07, 8'h20, 8'h30, 8'h66, 8'h67, 8'h41, 8'h00, 8'hAA};
    void'($urandom(32'd1234));
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rdata", io_rdata, 8'hFF);
    chk_ec("R1 ec outputs");
    // R3 locked: ignored writes, FF reads
    wr(8'h00, 8'h30); wr(8'h01, 8'h01);
    rd("R3 locked data read", 8'h01);
    rd("R3 locked index read", 8'h00);
    // R2 unlock
    wr(8'h00, 8'h55);
    rd("R2 unlocked index read", 8'h00);
    rreg("R5 select after reset", 8'h07);
    rreg("R3 locked write left no trace", 8'h30);
    // R6 chip id, write ignored
    wr(8'h00, 8'h20); wr(8'h01, 8'h00);
    rd("R6 chip id", 8'h01);
    // R4 other offset
    rd("R4 foreign offset", 8'h05);
    // R8, R9, R10 program EC device and a neighbour
    wr(8'h00, 8'h07); wr(8'h01, 8'h0C);
    wr(8'h00, 8'h66); wr(8'h01, 8'h34);
    wr(8'h00, 8'h67); wr(8'h01, 8'h12);
    wr(8'h00, 8'h30); wr(8'h01, 8'hFF);
    chk("R8 byte order", ec_base, 16'h1234);
    chk("R10 ec active", {15'b0, ec_active}, 16'h0001);
    rreg("R7 enable readback", 8'h30);
    wr(8'h00, 8'h07); wr(8'h01, 8'h03);
    wr(8'h00, 8'h66); wr(8'h01, 8'hAB);
    rreg("R9 neighbour low", 8'h66);
    chk_ec("R9 ec untouched");
    // R11 out-of-range select and unknown index
    wr(8'h00, 8'h07); wr(8'h01, 8'h20);
    wr(8'h00, 8'h67); wr(8'h01, 8'h77);
    rd("R11 out-of-range read", 8'h01);
    rreg("R11 unknown index", 8'h5A);
    chk_ec("R11 ec untouched");
    // R2 0x55 while unlocked loads index, then lock
    wr(8'h00, 8'h55);
    rd("R2 key as index", 8'h00);
    wr(8'h00, 8'hAA);
    rd("R2 relocked", 8'h01);
    wr(8'h01, 8'h00);
    chk_ec("R3 locked write no effect");
    wr(8'h00, 8'h55);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) wr(8'h00, ($urandom_range(0, 15) == 0) ? 8'h55 : pick[$urandom_range(0, 7)]);
      else if (op < 6) begin
        logic [7:0] d = $urandom;
        if (m_idx == 8'h07) d = {4'h0, d[3:0]} | (($urandom_range(0, 9) == 0) ? 8'h10 : 8'h00);
        wr(8'h01, d);
      end else if (op < 9) rd("R4 random read", 8'h01);
      else rd("R4 random index read", $urandom_range(0, 2));
      if (n % 16 == 0) chk_ec("R10 random");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule